// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Time Counter

This block keeps a free-running time-of-day value for precision time protocol timestamping. The visible time is a 64-bit count of whole nanoseconds, wide enough that it never needs a separate cycle counter or any wrap handling. Behind it sits a 32-bit fractional accumulator. On every clock cycle in which the counter is enabled, a programmable increment is added. The increment has an integer nanosecond part and a 32-bit fraction, and the carry out of the fraction feeds bit 0 of the nanosecond count.

Software reaches the block through a simple 32-bit register port with one-cycle read latency. The 64-bit time and the increment are each split into a low and a high word, with rules that make multi-word accesses atomic:
- Reading the low time word freezes a copy of the upper word, so the pair of reads forms one coherent sample.
- Writing a low word only stages it.
- Writing the matching high word commits the whole value in one cycle.

A link-speed code with a load strobe installs the default increment for that speed. The code for the slowest speed installs a zero increment, which stops the clock.

Top module: `ptp_tod_counter`

## Requirements
- R1: After reset the time reads 0, the control word reads 0 (counter disabled), the increment integer word reads 1 and the increment fraction word reads 0x99999999. Register addresses are: 0 control (bit 0 = enable), 1 time low, 2 time high, 3 increment fraction, 4 increment integer.
- R2: The time changes only while control bit 0 is 1. If the enable is written at clock edge k and cleared at edge k+M, the counter advances exactly M times.
- R3: Each enabled cycle adds the increment, with the fraction carry going into the nanosecond count. Starting from a committed time T0 with the accumulator clear, the time after M advances is T0 + floor(M*INC/2^32), where INC = {integer, fraction}. Carries cross the 32-bit word boundary.
- R4: A read of the time low word returns the live low 32 bits and captures the live upper 32 bits. A later read of the time high word returns that captured value, even if the time has been rewritten in between.
- R5: A write of the time low word alone leaves the time unchanged. A write of the time high word loads {high data, staged low} in one cycle and clears the fractional accumulator.
- R6: A write of the increment fraction word alone leaves the active increment unchanged. A write of the increment integer word installs {integer data, staged fraction}.
- R7: A pulse on speed_load installs the default increment for speed_code. The encoding is:

  | speed_code | Link speed | Integer | Fraction |
  |---|---|---|---|
  | 0 | 40G or no link | 1 | 0x99999999 |
  | 1 | 10G | 3 | 0x33333333 |
  | 2 | 1G | 0x20 | 0 |
  | 3 | 100M | 0 | 0 |

- R8: With a zero increment installed, the time stays constant even while the counter is enabled.
- R9: The read data for a read strobed at edge k appears on reg_rdata after edge k and holds until the next read. The increment integer word reads zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; one counter advance per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| speed_load | input | 1 | Load the default increment selected by speed_code |
| speed_code | input | 2 | Link speed code, encoded as in R7 |

## Verification
The assertions assume a few things about the inputs:
- reg_wr and reg_rd are never strobed in the same cycle.
- The time is never brought within one increment of the 64-bit limit, so the forward-only property cannot see a wrap.
- A speed load and a write of the increment integer word never coincide.

The stimulus keeps to these by issuing one bus operation per cycle from tasks and by committing only small time values, around the 32-bit boundary. The counting checks bracket each run between an enable write and a disable write, so the number of advances is exact and the expected time is computed with wide arithmetic in the bench.

// File: rtl/ptp_tod_pkg.sv
// Package: shared register addresses, widths and the per-speed default
// increment table for the nanosecond time counter.
package ptp_tod_pkg;
    localparam int WORD_W = 32;
    localparam int FRAC_W = 32;
    localparam int NS_W   = 64;

    typedef enum logic [2:0] {
        ADR_CTRL   = 3'd0,
        ADR_TLO    = 3'd1,
        ADR_THI    = 3'd2,
        ADR_IFRAC  = 3'd3,
        ADR_IINT   = 3'd4
    } reg_addr_e;

    // Default increment {integer[31:0], fraction[31:0]} per link speed code
    function automatic logic [63:0] speed_default(input logic [1:0] code);
        case (code)
            2'd0:    return 64'h0000_0001_9999_9999; // 1.6 ns
            2'd1:    return 64'h0000_0003_3333_3333; // 3.2 ns
            2'd2:    return 64'h0000_0020_0000_0000; // 32 ns
            default: return 64'h0;                   // stopped
        endcase
    endfunction
endpackage

// File: rtl/ptp_tod_regs.sv
// Register front end: decodes the bus, stages low words, keeps the upper
// time shadow captured by a low-word read and registers read data.
// Assumes reg_wr and reg_rd are not asserted together.
module ptp_tod_regs
    import ptp_tod_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [2:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [NS_W-1:0]   live_ns,
    input  logic [INT_W-1:0]  inc_int,
    input  logic [FRAC_W-1:0] inc_frac,
    output logic [WORD_W-1:0] rdata,
    output logic              en,
    output logic              time_ld,
    output logic [NS_W-1:0]   time_ld_val,
    output logic              inc_ld,
    output logic [INT_W-1:0]  inc_ld_int,
    output logic [FRAC_W-1:0] inc_ld_frac
);
    logic [WORD_W-1:0] stage_tlo;
    logic [FRAC_W-1:0] stage_ifrac;
    logic [WORD_W-1:0] shadow_hi;
    logic              rd_tlo;

    assign rd_tlo      = rd && (addr == ADR_TLO);
    assign time_ld     = wr && (addr == ADR_THI);
    assign time_ld_val = {wdata, stage_tlo};
    assign inc_ld      = wr && (addr == ADR_IINT);
    assign inc_ld_int  = wdata[INT_W-1:0];
    assign inc_ld_frac = stage_ifrac;

    // Control word: enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)                          en <= 1'b0;
        else if (wr && addr == ADR_CTRL)     en <= wdata[0];
    end

    // Staging registers for the low words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_tlo   <= '0;
            stage_ifrac <= '0;
        end else if (wr) begin
            if (addr == ADR_TLO)   stage_tlo   <= wdata;
            if (addr == ADR_IFRAC) stage_ifrac <= wdata;
        end
    end

    // Upper time shadow captured by a low-word read
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow_hi <= '0;
        else if (rd_tlo) shadow_hi <= live_ns[NS_W-1:WORD_W];
    end

    // Registered read data mux
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd) begin
            case (addr)
                ADR_CTRL:  rdata <= {{(WORD_W-1){1'b0}}, en};
                ADR_TLO:   rdata <= live_ns[WORD_W-1:0];
                ADR_THI:   rdata <= shadow_hi;
                ADR_IFRAC: rdata <= inc_frac;
                ADR_IINT:  rdata <= WORD_W'(inc_int);
                default:   rdata <= '0;
            endcase
        end
    end

    AST_SHADOW_ONLY_ON_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_tlo |=> $stable(shadow_hi)); // R4
endmodule

// File: rtl/ptp_tod_incr.sv
// Active increment register: loaded from a committed bus write or from the
// per-speed default table; a bus commit wins over a speed load.
module ptp_tod_incr
    import ptp_tod_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ld,
    input  logic [INT_W-1:0]  bus_int,
    input  logic [FRAC_W-1:0] bus_frac,
    input  logic              spd_ld,
    input  logic [1:0]        spd_code,
    output logic [INT_W-1:0]  inc_int,
    output logic [FRAC_W-1:0] inc_frac
);
    localparam logic [63:0] RST_INC = speed_default(2'd0);
    logic [63:0] dflt;

    assign dflt = speed_default(spd_code);

    // Increment update: bus commit, else speed default, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_int  <= RST_INC[FRAC_W +: INT_W];
            inc_frac <= RST_INC[FRAC_W-1:0];
        end else if (bus_ld) begin
            inc_int  <= bus_int;
            inc_frac <= bus_frac;
        end else if (spd_ld) begin
            inc_int  <= dflt[FRAC_W +: INT_W];
            inc_frac <= dflt[FRAC_W-1:0];
        end
    end

    AST_INC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ld && !spd_ld) |=> ($stable(inc_int) && $stable(inc_frac))); // R6
endmodule

// File: rtl/ptp_tod_accum.sv
// Time accumulator: whole nanoseconds plus a hidden fraction; adds the
// increment each enabled cycle; a commit loads the time and clears the fraction.
// Assumes the time never comes within one increment of the 64-bit limit.
module ptp_tod_accum
    import ptp_tod_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ld,
    input  logic [NS_W-1:0]   ld_val,
    input  logic [INT_W-1:0]  inc_int,
    input  logic [FRAC_W-1:0] inc_frac,
    output logic [NS_W-1:0]   ns
);
    logic [FRAC_W-1:0] frac;
    logic [FRAC_W:0]   frac_sum;
    logic [NS_W-1:0]   ns_next;

    assign frac_sum = {1'b0, frac} + {1'b0, inc_frac};
    assign ns_next  = ns + NS_W'(inc_int) + NS_W'(frac_sum[FRAC_W]);

    // Time and fraction update: commit first, then advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ns   <= '0;
            frac <= '0;
        end else if (ld) begin
            ns   <= ld_val;
            frac <= '0;
        end else if (en) begin
            ns   <= ns_next;
            frac <= frac_sum[FRAC_W-1:0];
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !ld) |=> ($stable(ns) && $stable(frac))); // R2
    AST_ZERO_INC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld && inc_int == '0 && inc_frac == '0) |=> $stable(ns)); // R8
    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (ns == $past(ld_val) && frac == '0)); // R5
    AST_NO_BACKWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ld) |=> (ns >= $past(ns))); // R3
endmodule

// File: rtl/ptp_tod_counter.sv
// Top: 64-bit nanosecond time-of-day counter with fractional increment,
// 32-bit register port and link-speed default increment loading.
module ptp_tod_counter
    import ptp_tod_pkg::*;
#(
    parameter int INT_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        speed_load,
    input  logic [1:0]  speed_code
);
    logic              en, time_ld, inc_ld;
    logic [NS_W-1:0]   ns, time_ld_val;
    logic [INT_W-1:0]  inc_int, inc_ld_int;
    logic [FRAC_W-1:0] inc_frac, inc_ld_frac;

    ptp_tod_regs #(.INT_W(INT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .live_ns(ns), .inc_int(inc_int), .inc_frac(inc_frac),
        .rdata(reg_rdata), .en(en), .time_ld(time_ld), .time_ld_val(time_ld_val),
        .inc_ld(inc_ld), .inc_ld_int(inc_ld_int), .inc_ld_frac(inc_ld_frac)
    );

    ptp_tod_incr #(.INT_W(INT_W)) u_incr (
        .clk(clk), .rst_n(rst_n), .bus_ld(inc_ld), .bus_int(inc_ld_int),
        .bus_frac(inc_ld_frac), .spd_ld(speed_load), .spd_code(speed_code),
        .inc_int(inc_int), .inc_frac(inc_frac)
    );

    ptp_tod_accum #(.INT_W(INT_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .en(en), .ld(time_ld), .ld_val(time_ld_val),
        .inc_int(inc_int), .inc_frac(inc_frac), .ns(ns)
    );

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R9
endmodule

// File: tb/ptp_tod_counter_tb.sv
// Scoreboard bench: read tasks push expected words, a monitor pops and compares.
module ptp_tod_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        speed_load = 1'b0;
    logic [1:0]  speed_code = '0;

    int checks = 0, failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [63:0] t_now;

    localparam logic [63:0] INC40 = 64'h1_9999_9999;

    always #2 clk = ~clk; // 250 MHz

    ptp_tod_counter u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .speed_load(speed_load), .speed_code(speed_code)
    );

    always @(posedge clk) rd_seen <= reg_rd;

    // Monitor: compare read data one cycle after each read strobe
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (reg_rdata !== e) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
            end
        end
    end

    function automatic logic [63:0] adv(input logic [63:0] t0, input int m,
                                        input logic [63:0] inc);
        logic [127:0] p;
        p = 128'(m) * 128'(inc);
        return t0 + p[95:32];
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run(input int m);
        wr(3'd0, 32'd1);
        idle(m - 1);
        wr(3'd0, 32'd0);
    endtask

    task automatic spd(input logic [1:0] c);
        speed_load = 1'b1; speed_code = c;
        @(negedge clk);
        speed_load = 1'b0;
    endtask

    task automatic set_time(input logic [63:0] t);
        wr(3'd1, t[31:0]);
        wr(3'd2, t[63:32]);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R9: reset values and read path
        rd_exp(3'd0, 32'd0, "R1 ctrl");
        rd_exp(3'd1, 32'd0, "R1 time lo");
        rd_exp(3'd2, 32'd0, "R1 time hi");
        rd_exp(3'd3, 32'h9999_9999, "R1 inc frac");
        rd_exp(3'd4, 32'd1, "R9 inc int zero-extended");
        // R2: disabled counter holds
        idle(20);
        rd_exp(3'd1, 32'd0, "R2 disabled hold");
        // R5: low write stages only; high write commits
        wr(3'd1, 32'hFFFF_FFF0);
        rd_exp(3'd1, 32'd0, "R5 low staged only");
        wr(3'd2, 32'd5);
        rd_exp(3'd1, 32'hFFFF_FFF0, "R5 commit lo");
        rd_exp(3'd2, 32'd5, "R5 commit hi");
        // R3 / R2: exact advance count across word boundary
        run(100);
        t_now = adv(64'h5_FFFF_FFF0, 100, INC40);
        rd_exp(3'd1, t_now[31:0], "R3 lo after 100");
        rd_exp(3'd2, t_now[63:32], "R3 hi after 100");
        // R4: shadow survives a time rewrite
        rd_exp(3'd1, t_now[31:0], "R4 snapshot lo");
        set_time(64'h77_0000_1234);
        rd_exp(3'd2, t_now[63:32], "R4 shadow hi");
        rd_exp(3'd1, 32'h1234, "R4 new lo");
        rd_exp(3'd2, 32'h77, "R4 new hi");
        // R6: fraction staged until integer write
        wr(3'd3, 32'd0);
        rd_exp(3'd3, 32'h9999_9999, "R6 frac staged");
        wr(3'd4, 32'd4);
        rd_exp(3'd3, 32'd0, "R6 frac committed");
        rd_exp(3'd4, 32'd4, "R6 int committed");
        set_time(64'd0);
        run(10);
        rd_exp(3'd1, 32'd40, "R6 new increment used");
        // R7: speed defaults
        spd(2'd1);
        rd_exp(3'd3, 32'h3333_3333, "R7 10G frac");
        rd_exp(3'd4, 32'd3, "R7 10G int");
        spd(2'd2);
        rd_exp(3'd3, 32'd0, "R7 1G frac");
        rd_exp(3'd4, 32'h20, "R7 1G int");
        spd(2'd0);
        rd_exp(3'd3, 32'h9999_9999, "R7 40G frac");
        rd_exp(3'd4, 32'd1, "R7 40G int");
        // R5: commit clears fractional accumulator
        set_time(64'd0);
        run(3);
        rd_exp(3'd1, 32'd4, "R3 fraction carry");
        set_time(64'd100);
        run(2);
        rd_exp(3'd1, adv(64'd100, 2, INC40) >> 0 & 32'hFFFF_FFFF, "R5 fraction cleared");
        // R8: zero increment freezes
        spd(2'd3);
        rd_exp(3'd4, 32'd0, "R7 100M int");
        run(50);
        rd_exp(3'd1, 32'd103, "R8 frozen lo");
        rd_exp(3'd2, 32'd0, "R8 frozen hi");
        idle(3);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R9 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule